// File: doc/BRIEF.md
# Two-Core Mailbox Link

This block joins two processor cores with a pair of word queues, one for each direction. Each core sees a two-register window. A status register, which software can only read, shows whether words from the partner are waiting and whether the outgoing queue can take another word. A data register carries the traffic. A write to it sends a word to the partner. A read from it takes the oldest word that the partner sent.

Software polls the status register, or relies on a notification mechanism outside this block, and then moves words through the data register. The link is atomic at word granularity and raises no interrupt. A build-time switch turns the link off. In that mode both registers of both cores read as zero and all accesses are inert.

Each core port has a one-bit register select, a write strobe, a read strobe and a write word. Read data is registered. A read strobed in cycle t therefore presents its value on the read-data output after the clock edge that ends cycle t. In every cycle without a read, that output is zero.

Top module: `mbx_link`

## Requirements
- R1: A synchronous active-high reset empties both queues. After reset, the status register of each core reads 0x00000002 and its data register reads 0.
- R2: Status bit 0 reads 1 exactly when the queue filled by the partner core holds at least one word.
- R3: Status bit 1 reads 1 exactly when this core's outgoing queue holds fewer than DEPTH words (DEPTH = 4 by default).
- R4: Status bits WIDTH-1:2 always read 0, and a write with select = 0 (status) changes no queue.
- R5: A write with select = 1 (data) appends the word to this core's outgoing queue. The partner reads the words back in the order they were written.
- R6: A read with select = 1 pops the oldest incoming word. The word appears on the read-data output one cycle later. A read with select = 0 returns the status. A cycle without a read yields 0.
- R7: A data read while the incoming queue is empty returns 0 and changes no state.
- R8: A data write while the outgoing queue is full is dropped. Queue contents and order are unchanged.
- R9: One core writing a queue while the other core reads the same queue in the same cycle are both serviced, provided the queue is neither full nor empty before the edge.
- R10: With ENABLE = 0, every read of either register on either core returns 0.
- R11: The two directions are independent. Traffic in one direction never changes the contents or flags of the other direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| c0_sel | input | 1 | Core 0 register select: 0 status, 1 data |
| c0_wr | input | 1 | Core 0 write strobe |
| c0_rd | input | 1 | Core 0 read strobe |
| c0_wdata | input | WIDTH | Core 0 write word |
| c0_rdata | output | WIDTH | Core 0 registered read word |
| c1_sel | input | 1 | Core 1 register select: 0 status, 1 data |
| c1_wr | input | 1 | Core 1 write strobe |
| c1_rd | input | 1 | Core 1 read strobe |
| c1_wdata | input | WIDTH | Core 1 write word |
| c1_rdata | output | WIDTH | Core 1 registered read word |

## Verification
Directed runs first fill one queue past its capacity, to expose overflow dropping. They then drain it below empty, to expose the zero-return path. Writes aimed at the status register follow, to show that they are inert. The main sweep steps through all 64 combinations of select, write and read on both cores at once, repeated over several rounds with changing data. This applies simultaneous push and pop, cross-direction traffic and mixed status/data access from every queue occupancy the rounds reach. The sweep thereby separates correct FIFO ordering from pointer slips, and separates direction isolation from cross-wiring. A disabled copy receives the same stimulus and must return zero throughout. A mid-run reset shows that both queues really empty.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_DATA   = 1'b1
  } mbx_reg_e;

  localparam int RX_AVAIL_BIT = 0;
  localparam int TX_FREE_BIT  = 1;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    count_q;
  logic             push_ok, pop_ok;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CAP);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem[rp_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R8: a push into a full queue without a pop leaves it full and unchanged
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (full_o && push_i && !pop_i) |=> (full_o && wp_q == $past(wp_q)));

  // R9: push and pop together keep the occupancy
  p_push_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !full_o && !empty_o) |=> (count_q == $past(count_q)));

  // R7: a pop from an empty queue moves nothing
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
    (empty_o && pop_i && !push_i) |=> (empty_o && rp_q == $past(rp_q)));

  // R3: occupancy never exceeds capacity
  p_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count_q <= CAP);
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter bit ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             tx_full_i,
  input  logic             rx_empty_i,
  input  logic [WIDTH-1:0] rx_head_i,
  output logic             push_o,
  output logic [WIDTH-1:0] push_data_o,
  output logic             pop_o,
  output logic [WIDTH-1:0] rdata_o
);
  mbx_reg_e         reg_sel;
  logic [WIDTH-1:0] status_w;

  assign reg_sel     = mbx_reg_e'(sel_i);
  assign push_o      = ENABLE && wr_i && (reg_sel == REG_DATA);
  assign pop_o       = ENABLE && rd_i && (reg_sel == REG_DATA);
  assign push_data_o = wdata_i;

  always_comb begin
    status_w               = '0;
    status_w[RX_AVAIL_BIT] = !rx_empty_i;
    status_w[TX_FREE_BIT]  = !tx_full_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (ENABLE && rd_i) begin
      if (reg_sel == REG_STATUS) rdata_o <= status_w;
      else                       rdata_o <= rx_empty_i ? '0 : rx_head_i;
    end else begin
      rdata_o <= '0;
    end
  end

  // R4: upper status bits read zero
  p_status_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_i && sel_i == 1'b0) |=> (rdata_o[WIDTH-1:2] == '0));

  // R7: empty data read returns zero
  p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_i && sel_i && rx_empty_i) |=> (rdata_o == '0));

  // R6: idle cycles return zero
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_o == '0));

  generate
    if (!ENABLE) begin : g_off
      // R10: a disabled link reads zero
      p_off_zero_r10: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> (rdata_o == '0));
    end
  endgenerate
endmodule

// File: rtl/mbx_link.sv
module mbx_link #(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 4,
  parameter bit ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             c0_sel,
  input  logic             c0_wr,
  input  logic             c0_rd,
  input  logic [WIDTH-1:0] c0_wdata,
  output logic [WIDTH-1:0] c0_rdata,
  input  logic             c1_sel,
  input  logic             c1_wr,
  input  logic             c1_rd,
  input  logic [WIDTH-1:0] c1_wdata,
  output logic [WIDTH-1:0] c1_rdata
);
  localparam int NCORE = 2;

  logic             sel   [NCORE];
  logic             wr    [NCORE];
  logic             rd    [NCORE];
  logic [WIDTH-1:0] wdata [NCORE];
  logic [WIDTH-1:0] rdata [NCORE];
  logic             push  [NCORE];
  logic [WIDTH-1:0] pdata [NCORE];
  logic             pop   [NCORE];
  logic [WIDTH-1:0] head  [NCORE];
  logic             empty [NCORE];
  logic             full  [NCORE];

  assign sel[0] = c0_sel;  assign wr[0] = c0_wr;  assign rd[0] = c0_rd;  assign wdata[0] = c0_wdata;
  assign sel[1] = c1_sel;  assign wr[1] = c1_wr;  assign rd[1] = c1_rd;  assign wdata[1] = c1_wdata;
  assign c0_rdata = rdata[0];
  assign c1_rdata = rdata[1];

  // queue k carries words sent by core k; it is drained by the partner's pop
  generate
    for (genvar k = 0; k < NCORE; k++) begin : g_core
      mbx_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push[k]),
        .data_i  (pdata[k]),
        .pop_i   (pop[NCORE-1-k]),
        .head_o  (head[k]),
        .empty_o (empty[k]),
        .full_o  (full[k])
      );

      mbx_port #(.WIDTH(WIDTH), .ENABLE(ENABLE)) u_port (
        .clk         (clk),
        .rst         (rst),
        .sel_i       (sel[k]),
        .wr_i        (wr[k]),
        .rd_i        (rd[k]),
        .wdata_i     (wdata[k]),
        .tx_full_i   (full[k]),
        .rx_empty_i  (empty[NCORE-1-k]),
        .rx_head_i   (head[NCORE-1-k]),
        .push_o      (push[k]),
        .push_data_o (pdata[k]),
        .pop_o       (pop[k]),
        .rdata_o     (rdata[k])
      );
    end
  endgenerate

  // R11: core 0 traffic alone never changes the fullness of core 1's outgoing queue
  p_isolated_r11: assert property (@(posedge clk) disable iff (rst)
    (!c1_wr && !c0_rd) |=> (full[1] == $past(full[1])));
endmodule

// File: tb/test_mbx_link.sv
module test_mbx_link;
  localparam int W = 32;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s0 = 0, w0 = 0, r0 = 0, s1 = 0, w1 = 0, r1 = 0;
  logic [W-1:0] d0 = '0, d1 = '0;
  logic [W-1:0] q0, q1, z0, z1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [W-1:0] qa [$]; // words sent by core 0
  logic [W-1:0] qb [$]; // words sent by core 1

  always #5 clk = ~clk;

  mbx_link #(.WIDTH(W), .DEPTH(D), .ENABLE(1'b1)) i_mbx_link (
    .clk(clk), .rst(rst),
    .c0_sel(s0), .c0_wr(w0), .c0_rd(r0), .c0_wdata(d0), .c0_rdata(q0),
    .c1_sel(s1), .c1_wr(w1), .c1_rd(r1), .c1_wdata(d1), .c1_rdata(q1));

  mbx_link #(.WIDTH(W), .DEPTH(D), .ENABLE(1'b0)) i_mbx_link_off (
    .clk(clk), .rst(rst),
    .c0_sel(s0), .c0_wr(w0), .c0_rd(r0), .c0_wdata(d0), .c0_rdata(z0),
    .c1_sel(s1), .c1_wr(w1), .c1_rd(r1), .c1_wdata(d1), .c1_rdata(z1));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // one bus cycle on both cores; expectations from the queue model
  task automatic cyc(input logic a0, input logic wa, input logic ra, input logic [W-1:0] da,
                     input logic a1, input logic wb, input logic rb, input logic [W-1:0] db,
                     input string tag);
    logic [W-1:0] e0, e1;
    int na, nb;
    na = qa.size();
    nb = qb.size();
    e0 = '0;
    e1 = '0;
    if (ra) e0 = a0 ? ((nb == 0) ? '0 : qb[0]) : {30'd0, (na < D), (nb != 0)};
    if (rb) e1 = a1 ? ((na == 0) ? '0 : qa[0]) : {30'd0, (nb < D), (na != 0)};
    s0 = a0; w0 = wa; r0 = ra; d0 = da;
    s1 = a1; w1 = wb; r1 = rb; d1 = db;
    @(posedge clk);
    #1;
    chk(tag, q0, e0);
    chk(tag, q1, e1);
    chk("R10", z0, '0);
    chk("R10", z1, '0);
    if (ra && a0 && nb != 0) void'(qb.pop_front());
    if (rb && a1 && na != 0) void'(qa.pop_front());
    if (wa && a0 && na < D) qa.push_back(da);
    if (wb && a1 && nb < D) qb.push_back(db);
    s0 = 0; w0 = 0; r0 = 0; s1 = 0; w1 = 0; r1 = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    qa.delete();
    qb.delete();
  endtask

  initial begin
    do_reset();
    // R1: reset state
    cyc(0, 0, 1, '0, 0, 0, 1, '0, "R1");
    cyc(1, 0, 1, '0, 1, 0, 1, '0, "R1");
    // R5 / R8: fill core 0 queue beyond capacity
    for (int i = 0; i < D + 2; i++)
      cyc(1, 1, 0, 32'hA5000000 + i, 0, 0, 0, '0, "R8");
    // R2 / R3: status now shows full and waiting
    cyc(0, 0, 1, '0, 0, 0, 1, '0, "R3");
    // R4: status writes are inert
    cyc(0, 1, 0, 32'hFFFFFFFF, 0, 1, 0, 32'hFFFFFFFF, "R4");
    cyc(0, 0, 1, '0, 0, 0, 1, '0, "R4");
    // R6 / R7: drain past empty
    for (int i = 0; i < D + 2; i++)
      cyc(0, 0, 0, '0, 1, 0, 1, '0, "R6");
    cyc(1, 0, 1, '0, 1, 0, 1, '0, "R7");
    // R9: write and read the same queue together
    cyc(1, 1, 0, 32'h11111111, 0, 0, 0, '0, "R9");
    for (int i = 0; i < 6; i++)
      cyc(1, 1, 0, 32'h22220000 + i, 1, 0, 1, '0, "R9");
    // R11: reverse-direction traffic while core 0 queue holds a word
    for (int i = 0; i < 3; i++)
      cyc(0, 0, 1, '0, 1, 1, 0, 32'hBB000000 + i, "R11");
    // R6 / R9 / R11: sweep every access combination on both cores
    for (int rep = 0; rep < 6; rep++)
      for (int c = 0; c < 64; c++)
        cyc(c[0], c[1], c[2], 32'h9E3779B9 * (rep * 64 + c + 1),
            c[3], c[4], c[5], 32'h7F4A7C15 * (rep * 64 + c + 3), "R6/R9");
    // R1: mid-run reset empties both queues
    cyc(1, 1, 0, 32'hCAFE0000, 1, 1, 0, 32'hCAFE0001, "R5");
    do_reset();
    cyc(0, 0, 1, '0, 0, 0, 1, '0, "R1");
    cyc(1, 0, 1, '0, 1, 0, 1, '0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule